// File: doc/BRIEF.md
# SD Command Line Engine

This block runs the command half of an SD/SDIO host. Software loads a 32-bit argument and then writes a command word holding the index byte, the expected response length and three option flags. That write starts the transaction. The engine shifts a 48-bit frame out on the CMD line: the index byte, the argument, a CRC7 over those 40 bits and a stop bit. It then listens for the card's start bit and captures a response of programmable length. It checks the response CRC7 and sets a done flag, which also drives the interrupt output.

The length field gives the number of bits between the start bit and the end bit, minus one. A value of 45 covers a 48-bit short response and 133 covers a 136-bit long one. A long-response flag starts the CRC7 check at bit 8 of the received frame. A waive flag skips the check. A busy flag holds completion until the card releases DAT0. If no start bit arrives within a programmable number of clocks, the engine sets a timeout flag and completes. Response words are read back through the argument address, and a read index in the control register selects the word. One line bit moves per clock.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, the status register (address 2) reads 0, cmd_oe_o is 0, cmd_o is 1 and irq_o is 0.
- R2: A write to the command register (address 1) while idle starts a frame on cmd_o, most significant bit first, in the cycle after the write. The frame is 48 bits: the command word bits [7:0], the argument last written at address 0, the CRC7 and a stop bit of 1. cmd_oe_o is high for exactly those 48 cycles.
- R3: The CRC7 uses x^7+x^3+1 with a zero initial value over the 40 leading bits. For example, byte 0x40 with argument 0 ends the frame in 0x95, and byte 0x48 with argument 0x1AA ends it in 0x87.
- R4: When the command word field [15:8] holds V and V is nonzero, the engine waits after the frame for a 0 on cmd_i. It then captures V+3 bits, counting that start bit and the end bit. Counting the last received bit as bit 0, a read at address 0 returns captured bits [32k+39:32k+8], where k is control bit field [1:0] (address 3).
- R5: Status bit 2 (done) sets in the cycle after the end bit is sampled. Status bit 1 (CRC OK) is then set only if the CRC7 over the frame from its first bit up to the CRC field equals the 7 received CRC bits.
- R6: With command word bit 17 set, the CRC7 covers the frame from its bit 8 onward, so the first 8 received bits are excluded.
- R7: With command word bit 16 set, the response completes with done set and CRC OK left at 0.
- R8: With command word bit 18 set, done waits after the response until dat0_i is 1. When V is 0 it waits after the frame instead. Status bit 0 stays 1 during the wait.
- R9: If no start bit arrives within L+1 cycles after the frame, status bit 3 (timeout) and done are set, busy clears and CRC OK stays 0. L is control field [31:16] and resets to 64.
- R10: A status write clears done for a 1 in bit 2 and clears timeout for a 1 in bit 3. Zero bits have no effect. irq_o follows done. Starting a command clears done, timeout and CRC OK.
- R11: A command write while busy is ignored. No frame is sent, a read at address 1 keeps returning the running command word, and the running transaction completes normally.
- R12: With V = 0, no response is awaited: done is set in the cycle after the stop bit and CRC OK stays 0.
- R13: Status bit 0 (busy) is 1 from the cycle after a start write until the cycle done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one CMD line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 argument, 1 command, 2 status, 3 control |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 0 response word, 1 command, 2 status, 3 control |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Command done interrupt |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input from the card |
| dat0_i | input | 1 | DAT0 level, 0 while the card is busy |

## Verification
The assertions watch every cycle for the following. The frame ends in a stop bit and its output enable never breaks mid-frame. The receive bit index stays inside the programmed frame. A command word is never replaced while a transaction is running. A waived response never shows CRC OK. The DAT0 busy wait holds until release, and a timeout always comes with done. The bench scenarios are needed for the values that only a full exchange shows: the exact frame bits and CRC7, which response bits land in each read word, the pass or fail verdict for good and corrupted CRCs in short and long mode, the cycle at which the timeout fires, and the write-1-to-clear behaviour.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int HDR_BITS   = 40;
  localparam int FRAME_BITS = HDR_BITS + 8;

  typedef enum logic [1:0] {A_DATA = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2, A_CTRL = 2'd3} reg_addr_e;
  typedef enum logic [1:0] {S_IDLE, S_TX, S_RESP, S_BUSY} eng_state_e;
  typedef enum logic [1:0] {R_IDLE, R_WAIT, R_RECV} rx_state_e;

  typedef struct packed {
    logic       busy_chk;
    logic       long_crc;
    logic       no_crc;
    logic [7:0] len_m1;
    logic [7:0] idx;
  } cmd_word_t;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_hdr(logic [HDR_BITS-1:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = HDR_BITS - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_crc7_ser.sv
module sdc_crc7_ser
  import sdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc7_step(crc_o, bit_i);
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [HDR_BITS-1:0] hdr_i,
  output logic                cmd_o,
  output logic                oe_o,
  output logic                last_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  act_q;

  assign cmd_o  = sr_q[FRAME_BITS-1];
  assign oe_o   = act_q;
  assign last_o = act_q && (cnt_q == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      sr_q  <= {hdr_i, crc7_hdr(hdr_i), 1'b1};
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b1};
      cnt_q <= cnt_q + CNT_W'(1);
      if (last_o) act_q <= 1'b0;
    end
  end

  p_stop_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> cmd_o);
  p_oe_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !last_o && !start_i) |=> oe_o);
endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx
  import sdc_pkg::*;
#(
  parameter int RESP_W = 136,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [7:0]        len_m1_i,
  input  logic              long_i,
  input  logic [TO_W-1:0]   to_lim_i,
  input  logic              cmd_i,
  output logic              done_o,
  output logic              to_o,
  output logic              crc_ok_o,
  output logic [RESP_W-1:0] resp_o
);
  localparam int IX_W = 9;

  rx_state_e       st_q;
  logic [IX_W-1:0] idx_q;
  logic [TO_W-1:0] wcnt_q;
  logic [IX_W-1:0] end_idx, first_idx;
  logic            start_seen, feed, cap;
  logic [6:0]      crc;

  assign end_idx    = IX_W'(len_m1_i) + IX_W'(2);
  assign first_idx  = long_i ? IX_W'(8) : IX_W'(0);
  assign start_seen = (st_q == R_WAIT) && !cmd_i;
  assign done_o     = (st_q == R_RECV) && (idx_q == end_idx);
  assign to_o       = (st_q == R_WAIT) && cmd_i && (wcnt_q == to_lim_i);
  assign feed       = (start_seen && !long_i) ||
                      ((st_q == R_RECV) && (idx_q >= first_idx) && (idx_q < end_idx));
  assign cap        = start_seen || (st_q == R_RECV);
  // CRC bits are fed too: a clean frame leaves a zero residue
  assign crc_ok_o   = (crc == 7'd0);

  sdc_crc7_ser i_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (arm_i),
    .en_i  (feed && !arm_i),
    .bit_i (cmd_i),
    .crc_o (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= R_IDLE;
      idx_q  <= '0;
      wcnt_q <= '0;
      resp_o <= '0;
    end else if (arm_i) begin
      st_q   <= R_WAIT;
      idx_q  <= '0;
      wcnt_q <= '0;
      resp_o <= '0;
    end else begin
      if (cap) resp_o <= {resp_o[RESP_W-2:0], cmd_i};
      case (st_q)
        R_WAIT: begin
          if (start_seen) begin
            st_q  <= R_RECV;
            idx_q <= IX_W'(1);
          end else if (to_o) begin
            st_q <= R_IDLE;
          end else begin
            wcnt_q <= wcnt_q + TO_W'(1);
          end
        end
        R_RECV: begin
          if (done_o) st_q <= R_IDLE;
          else        idx_q <= idx_q + IX_W'(1);
        end
        default: ;
      endcase
    end
  end

  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == R_RECV) |-> (idx_q <= end_idx));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TO_W   = 16,
  parameter int TO_DEF = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  input  logic        cmd_i,
  input  logic        dat0_i
);
  localparam int WORDS  = 2 ** IDX_W;
  localparam int RESP_W = 32 * WORDS + 8;
  localparam int CMD_W  = $bits(cmd_word_t);
  localparam int TO_LSB = 16;

  eng_state_e      st_q;
  cmd_word_t       cmd_q;
  logic [31:0]     arg_q;
  logic            done_q, crc_ok_q, to_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [TO_W-1:0] to_lim_q;

  logic wr_cmd, start, tx_last, rx_arm, rx_done, rx_to, rx_crc_ok;
  logic [RESP_W-1:0] rx_resp;
  logic [31:0] ctrl_rd;

  assign wr_cmd = wr_en_i && (wr_addr_i == A_CMD);
  assign start  = wr_cmd && (st_q == S_IDLE);
  assign rx_arm = tx_last && (cmd_q.len_m1 != 8'd0);
  assign irq_o  = done_q;

  sdc_cmd_tx i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .hdr_i  ({wr_data_i[7:0], arg_q}),
    .cmd_o  (cmd_o),
    .oe_o   (cmd_oe_o),
    .last_o (tx_last)
  );

  sdc_resp_rx #(.RESP_W(RESP_W), .TO_W(TO_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (rx_arm),
    .len_m1_i(cmd_q.len_m1),
    .long_i  (cmd_q.long_crc),
    .to_lim_i(to_lim_q),
    .cmd_i   (cmd_i),
    .done_o  (rx_done),
    .to_o    (rx_to),
    .crc_ok_o(rx_crc_ok),
    .resp_o  (rx_resp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cmd_q    <= '0;
      arg_q    <= '0;
      done_q   <= 1'b0;
      crc_ok_q <= 1'b0;
      to_q     <= 1'b0;
      rd_idx_q <= '0;
      to_lim_q <= TO_W'(TO_DEF);
    end else begin
      if (wr_en_i && (wr_addr_i == A_DATA)) arg_q <= wr_data_i;
      if (wr_en_i && (wr_addr_i == A_CTRL)) begin
        rd_idx_q <= wr_data_i[IDX_W-1:0];
        to_lim_q <= wr_data_i[TO_LSB +: TO_W];
      end
      if (wr_en_i && (wr_addr_i == A_STAT)) begin
        if (wr_data_i[2]) done_q <= 1'b0;
        if (wr_data_i[3]) to_q   <= 1'b0;
      end
      case (st_q)
        S_IDLE: if (start) begin
          st_q     <= S_TX;
          cmd_q    <= cmd_word_t'(wr_data_i[CMD_W-1:0]);
          done_q   <= 1'b0;
          crc_ok_q <= 1'b0;
          to_q     <= 1'b0;
        end
        S_TX: if (tx_last) begin
          if (cmd_q.len_m1 != 8'd0) st_q <= S_RESP;
          else if (cmd_q.busy_chk)  st_q <= S_BUSY;
          else begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_RESP: begin
          if (rx_to) begin
            st_q   <= S_IDLE;
            to_q   <= 1'b1;
            done_q <= 1'b1;
          end else if (rx_done) begin
            crc_ok_q <= rx_crc_ok && !cmd_q.no_crc;
            if (cmd_q.busy_chk) st_q <= S_BUSY;
            else begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_BUSY: if (dat0_i) begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[IDX_W-1:0] = rd_idx_q;
    ctrl_rd[TO_LSB +: TO_W] = to_lim_q;
  end

  always_comb begin
    case (rd_addr_i)
      A_DATA:  rd_data_o = rx_resp[32 * int'(rd_idx_q) + 8 +: 32];
      A_CMD:   rd_data_o = 32'(cmd_q);
      A_STAT:  rd_data_o = {28'd0, to_q, done_q, crc_ok_q, st_q != S_IDLE};
      default: rd_data_o = ctrl_rd;
    endcase
  end

  p_locked_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && st_q != S_IDLE) |=> $stable(cmd_q));
  p_waive_crc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RESP && rx_done && cmd_q.no_crc) |=> !crc_ok_q);
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_BUSY && !dat0_i) |=> (st_q == S_BUSY && !done_q));
  p_timeout_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> done_q);
  p_done_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (st_q == S_IDLE));
  p_oe_in_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> (st_q == S_TX));
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, cmd_o, cmd_oe;
  logic        cmd_i = 1'b1;
  logic        dat0 = 1'b1;

  always #5 clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .cmd_i(cmd_i), .dat0_i(dat0)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] arg;
    logic [7:0]  len;
    logic        busy;
    logic        lng;
    logic        nocrc;
    logic        bad;
    logic        exp_ok;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{6'd17, 32'h0000_1234, 8'd45,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{6'd8,  32'h0000_01AA, 8'd45,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{6'd2,  32'hDEAD_BEEF, 8'd133, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{6'd41, 32'h40FF_8000, 8'd45,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{6'd9,  32'h1234_5678, 8'd133, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  int n_run = 0, n_fail = 0;
  logic [15:0] to_lim = 16'd64;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic get_frame(output logic [47:0] f, output int n);
    n = 0; f = '0;
    while (cmd_oe && n < 60) begin
      f = {f[46:0], cmd_o};
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [6:0] crc_ref(logic [135:0] f, int n, int s);
    logic [6:0] r = '0;
    logic t;
    for (int i = s; i <= n - 9; i++) begin
      t = r[6] ^ f[n-1-i];
      r = {r[5:0], 1'b0};
      if (t) r = r ^ 7'h09;
    end
    return r;
  endfunction

  function automatic logic [135:0] mk_resp(vec_t v);
    logic [135:0] f = '0;
    int n = int'(v.len) + 3;
    if (v.lng) begin
      f[135:128] = 8'h3F;
      f[127:8]   = {v.arg, ~v.arg, v.arg ^ 32'h5A5A_5A5A, v.arg[31:8]};
    end else begin
      f[47:40] = {2'b00, v.op};
      f[39:8]  = ~v.arg;
    end
    f[7:1] = crc_ref(f, n, v.lng ? 8 : 0);
    f[0]   = 1'b1;
    if (v.bad) f[20] = ~f[20];
    return f;
  endfunction

  function automatic logic [47:0] exp_frame(logic [7:0] b, logic [31:0] a);
    logic [135:0] t = '0;
    t[47:8] = {b, a};
    t[7:1]  = crc_ref(t, 48, 0);
    t[0]    = 1'b1;
    return t[47:0];
  endfunction

  task automatic drive_resp(input logic [135:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      cmd_i = f[i];
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [47:0] fr;
    logic [135:0] rf;
    logic [31:0] cw;
    int n;

    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd2, r);
    chk("R1", "status", r, 32'h0);
    chk("R1", "oe/cmd/irq", {29'd0, cmd_oe, cmd_o, irq}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);

    // table of transactions: R2 R4 R5 R6 R7 R13
    for (int v = 0; v < 5; v++) begin
      cw = {13'd0, VECS[v].busy, VECS[v].lng, VECS[v].nocrc, VECS[v].len, 2'b01, VECS[v].op};
      wr(2'd0, VECS[v].arg);
      wr(2'd1, cw);
      rd(2'd2, r);
      chk("R13", "busy after start", {31'd0, r[0]}, 32'd1);
      get_frame(fr, n);
      chk("R2", "frame length", n, 48);
      chk("R2", "frame hi", {8'd0, fr[47:24]}, {8'd0, exp_frame({2'b01, VECS[v].op}, VECS[v].arg)} >> 24);
      chk("R2", "frame lo", {8'd0, fr[23:0]}, {8'd0, exp_frame({2'b01, VECS[v].op}, VECS[v].arg)} & 32'h00FF_FFFF);
      rf = mk_resp(VECS[v]);
      drive_resp(rf, int'(VECS[v].len) + 3);
      rd(2'd2, r);
      chk(VECS[v].nocrc ? "R7" : (VECS[v].lng ? "R6" : "R5"), "status after response",
          r, {28'd0, 1'b0, 1'b1, VECS[v].exp_ok, 1'b0});
      chk("R10", "irq follows done", {31'd0, irq}, 32'd1);
      for (int k = 0; k < (VECS[v].lng ? 4 : 1); k++) begin
        wr(2'd3, {to_lim, 14'd0, 2'(k)});
        rd(2'd0, r);
        chk("R4", "response word", r, rf[32*k+8 +: 32]);
      end
      wr(2'd3, {to_lim, 16'd0});
      wr(2'd2, 32'd4);
    end

    // R3 and R12: known CRC values, no response expected
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_0040);
    get_frame(fr, n);
    chk("R3", "CMD0 last byte", {24'd0, fr[7:0]}, 32'h95);
    rd(2'd2, r);
    chk("R12", "status after frame only", r, 32'h4);
    wr(2'd0, 32'h0000_01AA);
    wr(2'd1, 32'h0000_0048);
    rd(2'd2, r);
    chk("R10", "start clears done", {31'd0, r[2]}, 32'd0);
    get_frame(fr, n);
    chk("R3", "CMD8 last byte", {24'd0, fr[7:0]}, 32'h87);
    wr(2'd2, 32'd4);

    // R8: DAT0 busy hold
    dat0 = 1'b0;
    rf = mk_resp('{6'd7, 32'h0000_0900, 8'd45, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    wr(2'd0, 32'h0000_0900);
    wr(2'd1, {13'd0, 1'b1, 1'b0, 1'b0, 8'd45, 8'h47});
    get_frame(fr, n);
    drive_resp(rf, 48);
    repeat (10) @(negedge clk);
    rd(2'd2, r);
    chk("R8", "held while DAT0 low", r, 32'h3);
    dat0 = 1'b1;
    @(negedge clk);
    rd(2'd2, r);
    chk("R8", "done after DAT0 release", r, 32'h6);
    wr(2'd2, 32'd4);

    // R9: timeout
    wr(2'd3, {16'd20, 16'd0});
    wr(2'd1, {13'd0, 3'b000, 8'd45, 8'h4D});
    get_frame(fr, n);
    repeat (10) @(negedge clk);
    rd(2'd2, r);
    chk("R9", "no early timeout", r, 32'h1);
    repeat (20) @(negedge clk);
    rd(2'd2, r);
    chk("R9", "timeout status", r, 32'hC);

    // R10: write-1-to-clear
    wr(2'd2, 32'd0);
    rd(2'd2, r);
    chk("R10", "zero write no effect", r, 32'hC);
    wr(2'd2, 32'd8);
    rd(2'd2, r);
    chk("R10", "clear timeout only", r, 32'h4);
    wr(2'd2, 32'd4);
    rd(2'd2, r);
    chk("R10", "clear done", {28'd0, r[3:0]}, {31'd0, irq});
    chk("R10", "irq low", {31'd0, irq}, 32'd0);
    wr(2'd3, {to_lim, 16'd0});

    // R11: command write while busy
    rf = mk_resp('{6'd13, 32'hCAFE_0001, 8'd45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    cw = {13'd0, 3'b000, 8'd45, 8'h4D};
    wr(2'd0, 32'hCAFE_0001);
    wr(2'd1, cw);
    get_frame(fr, n);
    wr(2'd1, {13'd0, 3'b000, 8'd0, 8'h45});
    chk("R11", "no new frame", {31'd0, cmd_oe}, 32'd0);
    rd(2'd1, r);
    chk("R11", "command word kept", r, cw);
    drive_resp(rf, 48);
    rd(2'd2, r);
    chk("R11", "running command completes", r, 32'h6);
    rd(2'd0, r);
    chk("R11", "word of running command", r, rf[39:8]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule